// File: doc/BRIEF.md
# Output Pin Multiplexer

This block steers peripheral output signals onto three IO pad cells. Each pad cell owns a 2-bit selection register. The register loads a new code only on a clock edge where that cell's write strobe is high, and it keeps its code at every other edge. The pad's data and output enable both come from the peripheral output that the code picks in that pad's own code table.

The tables differ from pad to pad, so one function can sit under different codes on different pads. The same function, such as the I2C data line, can drive two pads at once. Once a code is held, the path from a peripheral's signals to the pad is purely combinational. A chip-level integration drives the strobes from its configuration logic and wires the pad outputs to its IO ring.

Code tables (value = source of pad out and outen):
- pad 0: 0 GPIO A bit 0, 1 UART transmit, 2 unassigned, 3 I2C data
- pad 1: 0 I2C clock, 1 GPIO A bit 1, 2 I2C data, 3 unassigned
- pad 2: 0 GPIO A bit 2, 1 UART transmit, 2 I2C clock, 3 unassigned

Top module: `pin_out_mux`

## Requirements
- R1: While `rstN` is low, every selection register is code 0, so pad 0 carries GPIO A bit 0, pad 1 carries the I2C clock and pad 2 carries GPIO A bit 2.
- R2: When `selWe[i]` is high at a rising clock edge, pad i takes the code `selIn[2i+1:2i]` from that edge on. Before the edge, the pad still shows its old routing.
- R3: When `selWe[i]` is low at an edge, pad i keeps its code, whatever `selIn` carries.
- R4: On pad 0, `padOut[0]` and `padOe[0]` follow the source that pad 0's table assigns to its held code.
- R5: On pad 1, `padOut[1]` and `padOe[1]` follow the source that pad 1's table assigns to its held code.
- R6: On pad 2, `padOut[2]` and `padOe[2]` follow the source that pad 2's table assigns to its held code.
- R7: An unassigned code drives both pad out and pad outen low.
- R8: A change on a selected peripheral input reaches the pad in the same cycle, with no clock edge needed.
- R9: With I2C data selected on pad 0 (code 3) and on pad 1 (code 2), both pads show its value together. Moving one of these pads to another code leaves the other pad still following I2C data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selIn | input | 6 | Selection codes, pad i in bits [2i+1:2i] |
| selWe | input | 3 | Per-pad write strobe for the selection code |
| gpioOut | input | 3 | GPIO bank A data, bits 0..2 |
| gpioOe | input | 3 | GPIO bank A output enables, bits 0..2 |
| sdaOut | input | 1 | I2C data output |
| sdaOe | input | 1 | I2C data output enable |
| sclOut | input | 1 | I2C clock output |
| sclOe | input | 1 | I2C clock output enable |
| uartTxOut | input | 1 | UART transmit data |
| uartTxOe | input | 1 | UART transmit output enable |
| padOut | output | 3 | Data to pad cells 0..2 |
| padOe | output | 3 | Output enable to pad cells 0..2 |

## Verification
The only internal state is the three held codes. If one of them is wrong, the pad shows the wrong source in the first cycle after the faulty edge. That is visible only when the intended source and the wrong source carry different values. The bench therefore keeps the peripheral inputs distinct and changing while it compares every pad on every clock against its own table model. A strobe that is ignored, or one that leaks onto the wrong cell, shows up on the pad one edge after the write.

// File: rtl/pin_mux_pkg.sv
package pin_mux_pkg;
  localparam int PAD_COUNT  = 3;
  localparam int SEL_W      = 2;
  localparam int CODE_COUNT = 1 << SEL_W;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_GPIO,
    SRC_SDA,
    SRC_SCL,
    SRC_UART
  } src_e;

  // one-hot decoded selection handed from control to datapath
  typedef struct packed {
    logic [CODE_COUNT-1:0] hot;
  } padRoute_t;

  typedef struct packed {
    logic out;
    logic oe;
  } drive_t;

  // per-pad code table
  function automatic src_e codeSource(input int pad, input int code);
    src_e s;
    s = SRC_NONE;
    case (pad)
      0: case (code)
           0: s = SRC_GPIO;
           1: s = SRC_UART;
           3: s = SRC_SDA;
           default: s = SRC_NONE;
         endcase
      1: case (code)
           0: s = SRC_SCL;
           1: s = SRC_GPIO;
           2: s = SRC_SDA;
           default: s = SRC_NONE;
         endcase
      2: case (code)
           0: s = SRC_GPIO;
           1: s = SRC_UART;
           2: s = SRC_SCL;
           default: s = SRC_NONE;
         endcase
      default: s = SRC_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pad_sel_ctrl.sv
module pad_sel_ctrl
  import pin_mux_pkg::*;
#(
  parameter int NUM_PADS = PAD_COUNT,
  parameter int SW       = SEL_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_PADS*SW-1:0]   selIn,
  input  logic [NUM_PADS-1:0]      selWe,
  output padRoute_t [NUM_PADS-1:0] route
);
  localparam int NC = 1 << SW;

  logic [SW-1:0] selQ [NUM_PADS];

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) selQ[p] <= '0;
      else if (selWe[p]) selQ[p] <= selIn[p*SW +: SW];
    end

    always_comb begin
      route[p].hot = '0;
      for (int c = 0; c < NC; c++) begin
        if (selQ[p] == SW'(c)) route[p].hot[c] = 1'b1;
      end
    end

    // R2: a strobed code is held from the next edge
    p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
      selWe[p] |=> selQ[p] == $past(selIn[p*SW +: SW]));

    // R3: no strobe, no change
    p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      !selWe[p] |=> $stable(selQ[p]));
  end
endmodule

// File: rtl/pad_route_dp.sv
module pad_route_dp
  import pin_mux_pkg::*;
#(
  parameter int NUM_PADS = PAD_COUNT,
  parameter int NC       = CODE_COUNT
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  padRoute_t [NUM_PADS-1:0] route,
  input  logic [NUM_PADS-1:0]      gpioOut,
  input  logic [NUM_PADS-1:0]      gpioOe,
  input  logic                     sdaOut,
  input  logic                     sdaOe,
  input  logic                     sclOut,
  input  logic                     sclOe,
  input  logic                     uartTxOut,
  input  logic                     uartTxOe,
  output logic [NUM_PADS-1:0]      padOut,
  output logic [NUM_PADS-1:0]      padOe
);
  drive_t cand [NUM_PADS][NC];
  drive_t sel  [NUM_PADS];

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    for (genvar c = 0; c < NC; c++) begin : g_code
      localparam src_e S = codeSource(p, c);
      if (S == SRC_GPIO)      begin : g_gpio assign cand[p][c] = {gpioOut[p], gpioOe[p]}; end
      else if (S == SRC_SDA)  begin : g_sda  assign cand[p][c] = {sdaOut, sdaOe}; end
      else if (S == SRC_SCL)  begin : g_scl  assign cand[p][c] = {sclOut, sclOe}; end
      else if (S == SRC_UART) begin : g_uart assign cand[p][c] = {uartTxOut, uartTxOe}; end
      else                    begin : g_none assign cand[p][c] = '0; end

      if (S == SRC_NONE) begin : g_chk_none
        // R7: an unassigned code drives the pad quiet
        p_unassigned_r7: assert property (@(posedge clk) disable iff (!rstN)
          route[p].hot[c] |-> (padOut[p] == 1'b0 && padOe[p] == 1'b0));
      end
    end

    always_comb begin
      sel[p] = '0;
      for (int c = 0; c < NC; c++) begin
        if (route[p].hot[c]) sel[p] = sel[p] | cand[p][c];
      end
    end

    assign padOut[p] = sel[p].out;
    assign padOe[p]  = sel[p].oe;

    // R4 R5 R6: exactly one code is routed per pad
    p_onehot_route_r4: assert property (@(posedge clk) disable iff (!rstN)
      $onehot(route[p].hot));
  end
endmodule

// File: rtl/pin_out_mux.sv
module pin_out_mux
  import pin_mux_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PAD_COUNT*SEL_W-1:0] selIn,
  input  logic [PAD_COUNT-1:0]   selWe,
  input  logic [PAD_COUNT-1:0]   gpioOut,
  input  logic [PAD_COUNT-1:0]   gpioOe,
  input  logic                   sdaOut,
  input  logic                   sdaOe,
  input  logic                   sclOut,
  input  logic                   sclOe,
  input  logic                   uartTxOut,
  input  logic                   uartTxOe,
  output logic [PAD_COUNT-1:0]   padOut,
  output logic [PAD_COUNT-1:0]   padOe
);
  padRoute_t [PAD_COUNT-1:0] route;

  pad_sel_ctrl #(.NUM_PADS(PAD_COUNT), .SW(SEL_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .selIn (selIn),
    .selWe (selWe),
    .route (route)
  );

  pad_route_dp #(.NUM_PADS(PAD_COUNT), .NC(CODE_COUNT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .route     (route),
    .gpioOut   (gpioOut),
    .gpioOe    (gpioOe),
    .sdaOut    (sdaOut),
    .sdaOe     (sdaOe),
    .sclOut    (sclOut),
    .sclOe     (sclOe),
    .uartTxOut (uartTxOut),
    .uartTxOe  (uartTxOe),
    .padOut    (padOut),
    .padOe     (padOe)
  );

  // R9: I2C data shared by pad 0 (code 3) and pad 1 (code 2)
  p_sda_shared_r9: assert property (@(posedge clk) disable iff (!rstN)
    (route[0].hot[3] && route[1].hot[2]) |->
      (padOut[0] == padOut[1] && padOe[0] == padOe[1]
       && padOut[0] == sdaOut && padOe[0] == sdaOe));
endmodule

// File: tb/tb_pin_out_mux.sv
module tb_pin_out_mux;
  logic       clk = 1'b0;
  logic       rstN;
  logic [5:0] selIn;
  logic [2:0] selWe;
  logic [2:0] gpioOut, gpioOe;
  logic       sdaOut, sdaOe, sclOut, sclOe, uartTxOut, uartTxOe;
  logic [2:0] padOut, padOe;

  int total = 0;
  int bad   = 0;
  bit autoChk = 1'b0;
  int mSel [3];

  always #2 clk = ~clk;

  pin_out_mux dut (
    .clk(clk), .rstN(rstN), .selIn(selIn), .selWe(selWe),
    .gpioOut(gpioOut), .gpioOe(gpioOe), .sdaOut(sdaOut), .sdaOe(sdaOe),
    .sclOut(sclOut), .sclOe(sclOe), .uartTxOut(uartTxOut), .uartTxOe(uartTxOe),
    .padOut(padOut), .padOe(padOe)
  );

  // behavioural routing table, returns {out, oe}
  function automatic logic [1:0] refDrive(int pad, int code);
    logic [1:0] g, sda, scl, tx;
    g   = {gpioOut[pad], gpioOe[pad]};
    sda = {sdaOut, sdaOe};
    scl = {sclOut, sclOe};
    tx  = {uartTxOut, uartTxOe};
    if (pad == 0) return (code == 0) ? g : (code == 1) ? tx : (code == 3) ? sda : 2'b00;
    if (pad == 1) return (code == 0) ? scl : (code == 1) ? g : (code == 2) ? sda : 2'b00;
    return (code == 0) ? g : (code == 1) ? tx : (code == 2) ? scl : 2'b00;
  endfunction

  function automatic logic [1:0] padPair(int pad);
    return {padOut[pad], padOe[pad]};
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference selection state
  always @(posedge clk or negedge rstN) begin
    if (!rstN) for (int i = 0; i < 3; i++) mSel[i] = 0;
    else for (int i = 0; i < 3; i++) if (selWe[i]) mSel[i] = int'(selIn[2*i +: 2]);
  end

  // per-clock comparison of every pad
  always @(negedge clk) begin
    if (autoChk && rstN) begin
      chk("R4 pad0", padPair(0), refDrive(0, mSel[0]));
      chk("R5 pad1", padPair(1), refDrive(1, mSel[1]));
      chk("R6 pad2", padPair(2), refDrive(2, mSel[2]));
    end
  end

  task automatic stepIn();
    @(posedge clk); #1;
  endtask

  task automatic writeSel(int pad, int code);
    selIn[2*pad +: 2] = 2'(code);
    selWe = 3'b000;
    selWe[pad] = 1'b1;
    stepIn();
    selWe = 3'b000;
  endtask

  task automatic randPeriph();
    gpioOut = 3'($urandom); gpioOe = 3'($urandom);
    {sdaOut, sdaOe, sclOut, sclOe, uartTxOut, uartTxOe} = 6'($urandom);
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; selIn = 6'b111111; selWe = 3'b111;
    gpioOut = 3'b111; gpioOe = 3'b111;
    sdaOut = 0; sdaOe = 0; sclOut = 1; sclOe = 0; uartTxOut = 0; uartTxOe = 0;
    #9;
    // R1: reset codes are 0 even with strobes high
    chk("R1 pad0", padPair(0), 2'b11);
    chk("R1 pad1", padPair(1), 2'b10);
    chk("R1 pad2", padPair(2), 2'b11);
    selWe = 3'b000;
    @(negedge clk); rstN = 1'b1;
    stepIn();
    autoChk = 1'b1;

    // R4 R5 R6 R7: every pad with every code under varied inputs
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 4; c++) begin
        writeSel(p, c);
        for (int k = 0; k < 6; k++) begin
          randPeriph();
          #1;
          if (refDrive(p, c) == 2'b00 && c == 3 - (p == 0 ? 1 : 0))
            chk("R7 unassigned", padPair(p), 2'b00);
          stepIn();
        end
      end
    end

    // R7: unassigned codes with all inputs high
    gpioOut = '1; gpioOe = '1;
    {sdaOut, sdaOe, sclOut, sclOe, uartTxOut, uartTxOe} = '1;
    writeSel(0, 2); writeSel(1, 3); writeSel(2, 3);
    chk("R7 pad0 code2", padPair(0), 2'b00);
    chk("R7 pad1 code3", padPair(1), 2'b00);
    chk("R7 pad2 code3", padPair(2), 2'b00);

    // R2: strobe visible only after the edge
    writeSel(0, 0);
    gpioOut = 3'b000; gpioOe = 3'b000; uartTxOut = 1; uartTxOe = 1;
    selIn[1:0] = 2'd1; selWe = 3'b001;
    #0.5;
    chk("R2 before edge", padPair(0), 2'b00);
    stepIn();
    selWe = 3'b000;
    chk("R2 after edge", padPair(0), 2'b11);

    // R3: codes on selIn without strobe are ignored
    selIn = 6'b101010;
    repeat (4) begin randPeriph(); stepIn(); end
    #1;
    chk("R3 hold pad0", padPair(0), {uartTxOut, uartTxOe});
    chk("R3 hold pad1", padPair(1), 2'b00);

    // R8: combinational path without clock
    writeSel(2, 0);
    @(negedge clk); #0.5;
    gpioOut[2] = ~gpioOut[2]; gpioOe[2] = 1'b1;
    #0.5;
    chk("R8 comb pad2", padPair(2), {gpioOut[2], 1'b1});

    // R9: shared I2C data on pads 0 and 1
    stepIn();
    writeSel(0, 3); writeSel(1, 2);
    for (int v = 0; v < 4; v++) begin
      {sdaOut, sdaOe} = 2'(v);
      #1;
      chk("R9 pad0 shared", padPair(0), 2'(v));
      chk("R9 pad1 shared", padPair(1), 2'(v));
    end
    stepIn();
    sdaOut = 1; sdaOe = 1; gpioOut[0] = 0; gpioOe[0] = 1;
    writeSel(0, 0);
    chk("R9 pad0 reselected", padPair(0), 2'b01);
    chk("R9 pad1 undisturbed", padPair(1), 2'b11);
    sdaOut = 0; #1;
    chk("R9 pad1 still follows", padPair(1), 2'b01);
    stepIn(); stepIn();

    autoChk = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule